// File: doc/BRIEF.md
# Bus Trigger Comparator with Capture Queue

This block watches the CPU bus for debug trigger conditions. Two address comparators, A and B, each test the bus address and can be limited to reads or to writes. A mode sequencer combines their results under one of nine trigger conditions: single match, either match, a sequence of A then B, an address match that also requires a data match or a data mismatch on B's data value, event-only storing on B, and two address-range tests. When a condition is met while the unit is armed, it emits a one-cycle breakpoint request. The request is either a tag request, which marks the fetched opcode, or a force request, which acts on any access.

A capture queue of eight 16-bit words records what happened around the trigger. In most modes it stores the bus address of each change-of-flow cycle. In the two event-only modes it instead stores the bus data byte of each qualifying B match. Recording can be set to end at the trigger. In that case the queue runs as a ring while armed, keeps the newest eight words, and the unit disarms when it triggers. Recording can instead be set to begin at the trigger. In that case it starts with the trigger cycle and stops once eight words are held. A debugger reads the queue, oldest word first, through a pop strobe and a count.

Top module: `dbg_trigger_unit`

## Requirements
- R1: After reset the unit is disarmed, both trigger outputs are low and the queue count is 0.
- R2: A comparator matches when the bus cycle is valid and its address equals the comparator address. When its R/W qualifier enable is 1, the bus R/W must also equal the configured R/W value (1 = read, 0 = write).
- R3: Mode code 0 triggers on an A match. Mode code 1 triggers on an A match or a B match.
- R4: Mode code 2 triggers on a B match in a cycle after an A match was latched. A B match before any A match does not trigger. Re-arming clears the latched A match.
- R5: Mode code 3 triggers on an A match whose bus data equals the B data value. Mode code 4 triggers on an A match whose bus data differs from it.
- R6: Mode code 5 triggers on a B match. Mode code 6 triggers on a B match after a latched A match. In both modes the queue stores the bus data byte, zero-extended to 16 bits, of each such B match and ignores change-of-flow cycles.
- R7: Mode code 7 triggers when A ≤ address ≤ B. Mode code 8 triggers when address < A or address > B. Both use A's R/W qualifier.
- R8: Mode codes 9 to 15 never trigger.
- R9: A trigger appears as a one-cycle pulse on the next clock: on trig_force when the force select is 1, otherwise on trig_tag. The unit triggers at most once per arm.
- R10: While disarmed, bus activity causes neither a trigger nor a queue write.
- R11: With end-at-trigger set, the queue stores the address of each change-of-flow cycle while armed and keeps the eight newest words. The unit disarms when it triggers.
- R12: With end-at-trigger clear, recording starts with the trigger cycle itself and stops accepting words once eight are held.
- R13: fifo_rdata shows the oldest stored word. A pop strobe while the count is nonzero removes that word, and fifo_count gives the number of words held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 4 | Trigger condition code 0..8 |
| cfg_addr_a | input | 16 | Comparator A address, lower range bound |
| cfg_addr_b | input | 16 | Comparator B address, upper range bound |
| cfg_data_b | input | 8 | Data value used by the full modes |
| cfg_rwen_a | input | 1 | Enable the R/W qualifier on A |
| cfg_rw_a | input | 1 | Required R/W for A (1 = read) |
| cfg_rwen_b | input | 1 | Enable the R/W qualifier on B |
| cfg_rw_b | input | 1 | Required R/W for B (1 = read) |
| cfg_force_brk | input | 1 | 1 = force request, 0 = tag request |
| cfg_end_at_trig | input | 1 | 1 = recording ends at trigger, 0 = begins at trigger |
| arm_set | input | 1 | Arm pulse; clears the queue and the sequence state |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 8 | Bus data |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_cof | input | 1 | Change-of-flow cycle marker |
| trig_tag | output | 1 | Tag breakpoint request pulse |
| trig_force | output | 1 | Force breakpoint request pulse |
| armed | output | 1 | Unit is armed |
| fifo_rd | input | 1 | Pop the oldest queue word |
| fifo_rdata | output | 16 | Oldest queue word |
| fifo_count | output | 4 | Words held in the queue |

## Verification
The bench targets the range edges, where an off-by-one comparison would drop a trigger at A or B itself or fire one address past them. It checks ordering in the sequenced modes, where a design that latched B or that kept the A latch across re-arm would fire early. It fills the queue past eight in both recording directions: a ring that failed to advance its read pointer would return stale old words, and a begin-mode queue that did not stop would overwrite the trigger-cycle word. It also tests event-only capture: storing flow addresses there, or storing B matches that come before A in mode 6, shows up as a wrong count or wrong data.

// File: rtl/dbgtrig_pkg.sv
package dbgtrig_pkg;

  typedef enum logic [3:0] {
    MD_A_ONLY     = 4'd0,
    MD_A_OR_B     = 4'd1,
    MD_A_THEN_B   = 4'd2,
    MD_FULL_MATCH = 4'd3,
    MD_FULL_MISS  = 4'd4,
    MD_EVT_B      = 4'd5,
    MD_A_THEN_EVT = 4'd6,
    MD_INSIDE     = 4'd7,
    MD_OUTSIDE    = 4'd8
  } trig_mode_e;

  function automatic logic rw_ok(input logic qual_en, input logic want, input logic rw);
    return !qual_en || (want == rw);
  endfunction

  function automatic logic in_window(input logic [15:0] addr, input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (addr >= lo) && (addr <= hi);
  endfunction

  function automatic logic off_window(input logic [15:0] addr, input logic [15:0] lo,
                                      input logic [15:0] hi);
    return (addr < lo) || (addr > hi);
  endfunction

endpackage

// File: rtl/dbgtrig_cmp.sv
module dbgtrig_cmp #(
  parameter int AW = 16
) (
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rw,
  input  logic [AW-1:0] ref_addr,
  input  logic          qual_en,
  input  logic          qual_rw,
  output logic          addr_hit
);
  import dbgtrig_pkg::*;

  assign addr_hit = bus_valid && (bus_addr == ref_addr) && rw_ok(qual_en, qual_rw, bus_rw);

endmodule

// File: rtl/dbgtrig_seq.sv
module dbgtrig_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  input  logic          live,
  input  logic          clr,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_rw,
  input  logic [AW-1:0] lo_addr,
  input  logic [AW-1:0] hi_addr,
  input  logic [DW-1:0] ref_data,
  input  logic          qual_en_a,
  input  logic          qual_rw_a,
  input  logic          hit_a,
  input  logic          hit_b,
  output logic          cond,
  output logic          b_event,
  output logic          evt_mode,
  output logic          a_seen
);
  import dbgtrig_pkg::*;

  logic data_eq;
  logic qual_a;
  logic seq_mode;

  assign data_eq  = (bus_data == ref_data);
  assign qual_a   = bus_valid && rw_ok(qual_en_a, qual_rw_a, bus_rw);
  assign seq_mode = (mode == MD_A_THEN_B) || (mode == MD_A_THEN_EVT);
  assign evt_mode = (mode == MD_EVT_B) || (mode == MD_A_THEN_EVT);
  assign b_event  = hit_b && ((mode == MD_EVT_B) || ((mode == MD_A_THEN_EVT) && a_seen));

  always_comb begin
    case (mode)
      MD_A_ONLY:     cond = hit_a;
      MD_A_OR_B:     cond = hit_a || hit_b;
      MD_A_THEN_B:   cond = a_seen && hit_b;
      MD_FULL_MATCH: cond = hit_a && data_eq;
      MD_FULL_MISS:  cond = hit_a && !data_eq;
      MD_EVT_B:      cond = hit_b;
      MD_A_THEN_EVT: cond = a_seen && hit_b;
      MD_INSIDE:     cond = qual_a && in_window(bus_addr, lo_addr, hi_addr);
      MD_OUTSIDE:    cond = qual_a && off_window(bus_addr, lo_addr, hi_addr);
      default:       cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           a_seen <= 1'b0;
    else if (clr)                         a_seen <= 1'b0;
    else if (live && seq_mode && hit_a)   a_seen <= 1'b1;
  end

  AST_ARM_CLEARS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !a_seen); // R4
  AST_SEQ_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_seen && !live) |=> !a_seen); // R10

endmodule

// File: rtl/dbgtrig_fifo.sv
module dbgtrig_fifo #(
  parameter int FW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [FW-1:0] wdata,
  input  logic          circ,
  input  logic          pop_req,
  output logic [FW-1:0] rdata,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [FW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          pop, has_room, push_ok, drop_old;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign pop      = pop_req && (count != '0);
  assign has_room = (count - CW'(pop)) < FULL;
  assign push_ok  = push && (has_room || circ);
  assign drop_old = push_ok && !has_room;
  assign rdata    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok)          wr_ptr <= bump(wr_ptr);
      if (pop || drop_old)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop) - CW'(drop_old);
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL); // R13
  AST_RING_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count == FULL && !pop_req) |=> count == FULL); // R11
  AST_STOP_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !circ && count == FULL && !pop_req) |=> $stable(rdata)); // R12

endmodule

// File: rtl/dbg_trigger_unit.sv
module dbg_trigger_unit #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int FW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [3:0]                   cfg_mode,
  input  logic [AW-1:0]                cfg_addr_a,
  input  logic [AW-1:0]                cfg_addr_b,
  input  logic [DW-1:0]                cfg_data_b,
  input  logic                         cfg_rwen_a,
  input  logic                         cfg_rw_a,
  input  logic                         cfg_rwen_b,
  input  logic                         cfg_rw_b,
  input  logic                         cfg_force_brk,
  input  logic                         cfg_end_at_trig,
  input  logic                         arm_set,
  input  logic                         bus_valid,
  input  logic [AW-1:0]                bus_addr,
  input  logic [DW-1:0]                bus_data,
  input  logic                         bus_rw,
  input  logic                         bus_cof,
  output logic                         trig_tag,
  output logic                         trig_force,
  output logic                         armed,
  input  logic                         fifo_rd,
  output logic [FW-1:0]                fifo_rdata,
  output logic [$clog2(DEPTH+1)-1:0]   fifo_count
);
  localparam int NCMP = 2;

  logic [AW-1:0] cmp_ref  [NCMP];
  logic          cmp_qen  [NCMP];
  logic          cmp_qrw  [NCMP];
  logic          cmp_hit  [NCMP];

  assign cmp_ref[0] = cfg_addr_a;  assign cmp_ref[1] = cfg_addr_b;
  assign cmp_qen[0] = cfg_rwen_a;  assign cmp_qen[1] = cfg_rwen_b;
  assign cmp_qrw[0] = cfg_rw_a;    assign cmp_qrw[1] = cfg_rw_b;

  for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
    dbgtrig_cmp #(.AW(AW)) u_cmp (
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .bus_rw    (bus_rw),
      .ref_addr  (cmp_ref[gi]),
      .qual_en   (cmp_qen[gi]),
      .qual_rw   (cmp_qrw[gi]),
      .addr_hit  (cmp_hit[gi])
    );
  end

  logic fired;
  logic live, cond, b_event, evt_mode, a_seen;
  logic trig_hit, rec_en, cap_evt, cap_push;
  logic [FW-1:0] cap_word;

  assign live = armed && !fired && !arm_set;

  dbgtrig_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (cfg_mode),
    .live      (live),
    .clr       (arm_set),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_rw    (bus_rw),
    .lo_addr   (cfg_addr_a),
    .hi_addr   (cfg_addr_b),
    .ref_data  (cfg_data_b),
    .qual_en_a (cfg_rwen_a),
    .qual_rw_a (cfg_rw_a),
    .hit_a     (cmp_hit[0]),
    .hit_b     (cmp_hit[1]),
    .cond      (cond),
    .b_event   (b_event),
    .evt_mode  (evt_mode),
    .a_seen    (a_seen)
  );

  assign trig_hit = live && cond;
  assign rec_en   = armed && !arm_set && (cfg_end_at_trig || fired || trig_hit);
  assign cap_evt  = evt_mode ? b_event : (bus_valid && bus_cof);
  assign cap_push = rec_en && cap_evt;
  assign cap_word = evt_mode ? FW'(bus_data) : FW'(bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      fired      <= 1'b0;
      trig_tag   <= 1'b0;
      trig_force <= 1'b0;
    end else if (arm_set) begin
      armed      <= 1'b1;
      fired      <= 1'b0;
      trig_tag   <= 1'b0;
      trig_force <= 1'b0;
    end else begin
      trig_tag   <= trig_hit && !cfg_force_brk;
      trig_force <= trig_hit && cfg_force_brk;
      if (trig_hit) begin
        fired <= 1'b1;
        if (cfg_end_at_trig) armed <= 1'b0;
      end
    end
  end

  dbgtrig_fifo #(.FW(FW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (arm_set),
    .push    (cap_push),
    .wdata   (cap_word),
    .circ    (cfg_end_at_trig),
    .pop_req (fifo_rd),
    .rdata   (fifo_rdata),
    .count   (fifo_count)
  );

  AST_TRIG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trig_tag, trig_force})); // R9
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && !arm_set) |=> !(trig_tag || trig_force)); // R9
  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !(trig_tag || trig_force)); // R10
  AST_END_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit && cfg_end_at_trig) |=> !armed); // R11
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm_set && !fifo_rd) |=> $stable(fifo_count)); // R10

endmodule

// File: tb/tb_dbg_trigger_unit.sv
`timescale 1ns/1ps
module tb_dbg_trigger_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_mode = '0;
  logic [15:0] cfg_addr_a = '0, cfg_addr_b = '0;
  logic [7:0]  cfg_data_b = '0;
  logic        cfg_rwen_a = 0, cfg_rw_a = 0, cfg_rwen_b = 0, cfg_rw_b = 0;
  logic        cfg_force_brk = 0, cfg_end_at_trig = 0, arm_set = 0;
  logic        bus_valid = 0, bus_rw = 0, bus_cof = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        trig_tag, trig_force, armed, fifo_rd = 0;
  logic [15:0] fifo_rdata;
  logic [3:0]  fifo_count;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_trigger_unit dut (.*);

  typedef struct packed {
    logic [3:0]  m;
    logic [15:0] a;
    logic [15:0] b;
    logic [7:0]  d;
    logic        rwen;
    logic        rwa;
    logic [15:0] ad;
    logic [7:0]  dt;
    logic        rw;
    logic        ex;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{4'd0,  16'h1000, 16'h2000, 8'h00, 1'b0, 1'b0, 16'h1000, 8'h00, 1'b1, 1'b1},
    '{4'd0,  16'h1000, 16'h2000, 8'h00, 1'b0, 1'b0, 16'h1001, 8'h00, 1'b1, 1'b0},
    '{4'd0,  16'h1000, 16'h2000, 8'h00, 1'b1, 1'b0, 16'h1000, 8'h00, 1'b1, 1'b0},
    '{4'd0,  16'h1000, 16'h2000, 8'h00, 1'b1, 1'b1, 16'h1000, 8'h00, 1'b1, 1'b1},
    '{4'd1,  16'h1000, 16'h2000, 8'h00, 1'b0, 1'b0, 16'h2000, 8'h00, 1'b0, 1'b1},
    '{4'd1,  16'h1000, 16'h2000, 8'h00, 1'b0, 1'b0, 16'h3000, 8'h00, 1'b0, 1'b0},
    '{4'd3,  16'h1000, 16'h2000, 8'h5A, 1'b0, 1'b0, 16'h1000, 8'h5A, 1'b0, 1'b1},
    '{4'd3,  16'h1000, 16'h2000, 8'h5A, 1'b0, 1'b0, 16'h1000, 8'h5B, 1'b0, 1'b0},
    '{4'd4,  16'h1000, 16'h2000, 8'h5A, 1'b0, 1'b0, 16'h1000, 8'h5B, 1'b0, 1'b1},
    '{4'd4,  16'h1000, 16'h2000, 8'h5A, 1'b0, 1'b0, 16'h1000, 8'h5A, 1'b0, 1'b0},
    '{4'd7,  16'h1000, 16'h1FFF, 8'h00, 1'b0, 1'b0, 16'h1000, 8'h00, 1'b1, 1'b1},
    '{4'd7,  16'h1000, 16'h1FFF, 8'h00, 1'b0, 1'b0, 16'h1FFF, 8'h00, 1'b1, 1'b1},
    '{4'd7,  16'h1000, 16'h1FFF, 8'h00, 1'b0, 1'b0, 16'h2000, 8'h00, 1'b1, 1'b0},
    '{4'd8,  16'h1000, 16'h1FFF, 8'h00, 1'b0, 1'b0, 16'h0FFF, 8'h00, 1'b1, 1'b1},
    '{4'd8,  16'h1000, 16'h1FFF, 8'h00, 1'b0, 1'b0, 16'h2000, 8'h00, 1'b1, 1'b1},
    '{4'd8,  16'h1000, 16'h1FFF, 8'h00, 1'b0, 1'b0, 16'h1800, 8'h00, 1'b1, 1'b0},
    '{4'd9,  16'h1000, 16'h2000, 8'h00, 1'b0, 1'b0, 16'h1000, 8'h00, 1'b1, 1'b0},
    '{4'd15, 16'h1000, 16'h2000, 8'h00, 1'b0, 1'b0, 16'h1000, 8'h00, 1'b1, 1'b0}
  };

  function automatic string req_of(input logic [3:0] m, input logic rwen);
    if (rwen) return "R2";
    case (m)
      4'd0, 4'd1: return "R3";
      4'd3, 4'd4: return "R5";
      4'd7, 4'd8: return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_arm();
    arm_set = 1'b1;
    @(negedge clk);
    arm_set = 1'b0;
  endtask

  task automatic bus_cyc(input logic [15:0] a, input logic [7:0] d, input logic rw,
                         input logic cof);
    bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_rw = rw; bus_cof = cof;
    @(negedge clk);
    bus_valid = 1'b0; bus_cof = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [15:0] exp);
    check(req, 32'(fifo_rdata), 32'(exp));
    fifo_rd = 1'b1;
    @(negedge clk);
    fifo_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", 32'(armed), 0);
    check("R1", 32'({trig_tag, trig_force}), 0);
    check("R1", 32'(fifo_count), 0);

    // R10 disarmed: matching bus and flow cycles have no effect
    cfg_mode = 4'd0; cfg_addr_a = 16'h1000; cfg_end_at_trig = 1'b1;
    bus_cyc(16'h1000, 8'h00, 1'b1, 1'b1);
    check("R10", 32'({trig_tag, trig_force}), 0);
    check("R10", 32'(fifo_count), 0);

    // Table walk: R2 R3 R5 R7 R8
    cfg_end_at_trig = 1'b0; cfg_force_brk = 1'b0;
    for (int i = 0; i < NV; i++) begin
      cfg_mode = TBL[i].m; cfg_addr_a = TBL[i].a; cfg_addr_b = TBL[i].b;
      cfg_data_b = TBL[i].d; cfg_rwen_a = TBL[i].rwen; cfg_rw_a = TBL[i].rwa;
      do_arm();
      bus_cyc(TBL[i].ad, TBL[i].dt, TBL[i].rw, 1'b0);
      check(req_of(TBL[i].m, TBL[i].rwen), 32'(trig_tag), 32'(TBL[i].ex));
      check("R9", 32'(trig_force), 0);
    end
    cfg_rwen_a = 1'b0;

    // R4 sequence, R9 force pulse and one shot
    cfg_mode = 4'd2; cfg_addr_a = 16'h0100; cfg_addr_b = 16'h0200; cfg_force_brk = 1'b1;
    do_arm();
    bus_cyc(16'h0200, 8'h00, 1'b1, 1'b0);
    check("R4", 32'(trig_force), 0);
    bus_cyc(16'h0100, 8'h00, 1'b1, 1'b0);
    check("R4", 32'(trig_force), 0);
    bus_cyc(16'h0200, 8'h00, 1'b1, 1'b0);
    check("R4", 32'(trig_force), 1);
    check("R9", 32'(trig_tag), 0);
    @(negedge clk);
    check("R9", 32'(trig_force), 0);
    bus_cyc(16'h0200, 8'h00, 1'b1, 1'b0);
    check("R9", 32'(trig_force), 0);
    do_arm();
    bus_cyc(16'h0200, 8'h00, 1'b1, 1'b0);
    check("R4", 32'(trig_force), 0);
    cfg_force_brk = 1'b0;

    // R11 end at trigger: ring keeps newest 8, disarm on trigger
    cfg_mode = 4'd0; cfg_addr_a = 16'hFFFF; cfg_end_at_trig = 1'b1;
    do_arm();
    for (int k = 0; k < 10; k++) bus_cyc(16'h0010 + 16'(k), 8'h00, 1'b1, 1'b1);
    check("R11", 32'(fifo_count), 8);
    bus_cyc(16'hFFFF, 8'h00, 1'b1, 1'b0);
    check("R11", 32'(trig_tag), 1);
    check("R11", 32'(armed), 0);
    bus_cyc(16'h0077, 8'h00, 1'b1, 1'b1);
    check("R11", 32'(fifo_count), 8);
    for (int k = 0; k < 8; k++) pop_check("R11", 16'h0012 + 16'(k));
    check("R13", 32'(fifo_count), 0);

    // R12 begin at trigger: starts with trigger cycle, stops when full
    cfg_addr_a = 16'h3000; cfg_end_at_trig = 1'b0;
    do_arm();
    bus_cyc(16'h0050, 8'h00, 1'b1, 1'b1);
    bus_cyc(16'h0051, 8'h00, 1'b1, 1'b1);
    check("R12", 32'(fifo_count), 0);
    bus_cyc(16'h3000, 8'h00, 1'b1, 1'b1);
    check("R12", 32'(trig_tag), 1);
    check("R12", 32'(fifo_count), 1);
    for (int k = 0; k < 9; k++) bus_cyc(16'h0060 + 16'(k), 8'h00, 1'b1, 1'b1);
    check("R12", 32'(fifo_count), 8);
    pop_check("R12", 16'h3000);
    pop_check("R13", 16'h0060);
    check("R13", 32'(fifo_count), 6);

    // R6 event-only B
    cfg_mode = 4'd5; cfg_addr_b = 16'h4000;
    do_arm();
    check("R13", 32'(fifo_count), 0);
    bus_cyc(16'h4000, 8'hA5, 1'b0, 1'b0);
    check("R6", 32'(trig_tag), 1);
    bus_cyc(16'h4001, 8'h77, 1'b0, 1'b0);
    bus_cyc(16'h4002, 8'h66, 1'b1, 1'b1);
    bus_cyc(16'h4000, 8'h3C, 1'b0, 1'b0);
    check("R6", 32'(trig_tag), 0);
    check("R6", 32'(fifo_count), 2);
    pop_check("R6", 16'h00A5);
    pop_check("R6", 16'h003C);

    // R6 A then event-only B
    cfg_mode = 4'd6; cfg_addr_a = 16'h0010; cfg_addr_b = 16'h0020;
    do_arm();
    bus_cyc(16'h0020, 8'h11, 1'b0, 1'b0);
    check("R6", 32'(trig_tag), 0);
    check("R6", 32'(fifo_count), 0);
    bus_cyc(16'h0010, 8'h00, 1'b1, 1'b0);
    bus_cyc(16'h0020, 8'h22, 1'b0, 1'b0);
    check("R6", 32'(trig_tag), 1);
    check("R6", 32'(fifo_count), 1);
    check("R6", 32'(fifo_rdata), 32'h22);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule